// File: doc/BRIEF.md
# Broadcast Storm Rate Limiter

This block sits on the receive side of one switch port and protects the rest of the fabric from flooding traffic. Each received frame is announced by a one-cycle start strobe together with its 48-bit destination address. The block classifies the frame and counts the flooding frames it sees inside a fixed time window. Once the count has reached the selected limit, every further flooding frame in that window gets a drop verdict. Frames that are not flooding traffic are never counted and never dropped.

The window is built from the system clock. Its length in clock ticks is set by two parameters, one for a port running at 100 Mbps and one for 10 Mbps. A live speed flag chooses between them, and the defaults match 10 ms and 100 ms at 50 MHz. A 2-bit select picks one of four limits, each of them a parameter. An option input decides whether group-addressed (multicast) frames count as flooding traffic or only the all-ones address does. A master enable turns the whole function off.

Top module: `bcast_storm_limiter`

## Requirements
- R1: While rst_ni is low, drop_o is low. After reset the count is zero and a fresh window begins, so the first frames of the limit are passed.
- R2: A frame whose address is all ones (da_i == 48'hFFFF_FFFF_FFFF) is always a counted frame, whatever the value of bcast_only_i.
- R3: The group bit is da_i[40], the least significant bit of the first address octet, which the bench places in da_i[47:40]. With bcast_only_i = 0, a frame with this bit set also counts. With bcast_only_i = 1, only the all-ones address counts.
- R4: A frame that does not count is never dropped and does not change the count, even while counted frames are being dropped.
- R5: Within one window, the first N counted frames pass and every later counted frame is dropped, where N is the selected limit.
- R6: thr_sel_i values 0, 1, 2 and 3 select THR_SEL0, THR_SEL1, THR_SEL2 and THR_SEL3. The defaults are 64, 128, 256 and 512.
- R7: A window lasts WIN_FAST_TICKS clock edges when speed100_i = 1 and WIN_SLOW_TICKS edges when it is 0. It ends on the last of these enabled edges, counted from the first enabled edge. A frame arriving on that edge belongs to the new window and is counted as its first frame.
- R8: While en_i is low, nothing is dropped, the count is held at zero and the window timer is held at its start. The first enabled edge after that is edge 1 of a new window.
- R9: drop_o is a one-cycle pulse. It is high in the cycle after the sof_i cycle of the dropped frame, and low in any cycle that does not follow a sof_i cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Master enable of the storm filter |
| speed100_i | input | 1 | 1: port at 100 Mbps (short window), 0: 10 Mbps (long window) |
| thr_sel_i | input | 2 | Selects the frame limit per window |
| bcast_only_i | input | 1 | 1: only the all-ones address counts; 0: group addresses count too |
| sof_i | input | 1 | One-cycle strobe marking a received frame |
| da_i | input | 48 | Destination address, first octet in bits 47:40 |
| drop_o | output | 1 | Drop verdict for the frame strobed in the previous cycle |

## Verification
A wrong count shows at the ports as soon as the limit is reached. The verdict flips one frame early or one frame late, on the frame that follows the limit. A wrong window timer shows only at the end of the window. Drops then continue past the boundary edge, or the count clears too early, so the bench times frames to land on the exact boundary edge and on the edge just before it. A classification fault shows on the very next non-counted frame in a storm, because its verdict comes back one cycle later as a drop.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
  localparam int unsigned DA_W = 48;
  localparam int unsigned GROUP_BIT = 40;

  typedef enum logic [1:0] {
    FC_UNICAST = 2'd0,
    FC_GROUP   = 2'd1,
    FC_ALLONES = 2'd2
  } frame_cls_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/bsl_timebase.sv
module bsl_timebase #(
  parameter int unsigned FAST_TICKS = 500000,
  parameter int unsigned SLOW_TICKS = 5000000,
  parameter int unsigned TMR_W      = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             speed100_i,
  output logic             tick_o,
  output logic [TMR_W-1:0] tmr_o
);
  localparam logic [TMR_W-1:0] LAST_FAST = TMR_W'(FAST_TICKS - 1);
  localparam logic [TMR_W-1:0] LAST_SLOW = TMR_W'(SLOW_TICKS - 1);

  logic [TMR_W-1:0] tmr_q;
  logic [TMR_W-1:0] last;

  assign last = speed100_i ? LAST_FAST : LAST_SLOW;
  // >= so a switch to the short window mid-way ends it at once
  assign tick_o = en_i && (tmr_q >= last);
  assign tmr_o  = tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tmr_q <= '0;
    else if (!en_i)  tmr_q <= '0;
    else if (tick_o) tmr_q <= '0;
    else             tmr_q <= tmr_q + 1'b1;
  end
endmodule

// File: rtl/bsl_classify.sv
module bsl_classify
  import bsl_pkg::*;
(
  input  logic [DA_W-1:0] da_i,
  input  logic            bcast_only_i,
  output frame_cls_e      cls_o,
  output logic            counted_o
);
  always_comb begin
    if (&da_i)               cls_o = FC_ALLONES;
    else if (da_i[GROUP_BIT]) cls_o = FC_GROUP;
    else                     cls_o = FC_UNICAST;
  end

  assign counted_o = (cls_o == FC_ALLONES) || ((cls_o == FC_GROUP) && !bcast_only_i);
endmodule

// File: rtl/bsl_gate.sv
module bsl_gate #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             drop_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             drop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      drop_q <= 1'b0;
    end else begin
      // frame on the boundary edge is judged against the fresh window
      drop_q <= en_i && hit_i && !tick_i && (cnt_q >= thr_i);
      if (!en_i)                      cnt_q <= '0;
      else if (tick_i)                cnt_q <= CNT_W'(hit_i && (thr_i != '0));
      else if (hit_i && cnt_q < thr_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign drop_o = drop_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/bcast_storm_limiter.sv
module bcast_storm_limiter
  import bsl_pkg::*;
#(
  parameter int unsigned WIN_FAST_TICKS = 500000,
  parameter int unsigned WIN_SLOW_TICKS = 5000000,
  parameter int unsigned THR_SEL0 = 64,
  parameter int unsigned THR_SEL1 = 128,
  parameter int unsigned THR_SEL2 = 256,
  parameter int unsigned THR_SEL3 = 512
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            speed100_i,
  input  logic [1:0]      thr_sel_i,
  input  logic            bcast_only_i,
  input  logic            sof_i,
  input  logic [DA_W-1:0] da_i,
  output logic            drop_o
);
  localparam int unsigned WIN_MAX = max2(WIN_FAST_TICKS, WIN_SLOW_TICKS);
  localparam int unsigned THR_MAX = max2(max2(THR_SEL0, THR_SEL1), max2(THR_SEL2, THR_SEL3));
  localparam int unsigned TMR_W   = $clog2(WIN_MAX + 1);
  localparam int unsigned CNT_W   = $clog2(THR_MAX + 1);

  logic             tick_w;
  logic [TMR_W-1:0] tmr_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] thr_w;
  logic             counted_w;
  frame_cls_e       cls_w;

  always_comb begin
    unique case (thr_sel_i)
      2'd0:    thr_w = CNT_W'(THR_SEL0);
      2'd1:    thr_w = CNT_W'(THR_SEL1);
      2'd2:    thr_w = CNT_W'(THR_SEL2);
      default: thr_w = CNT_W'(THR_SEL3);
    endcase
  end

  bsl_timebase #(
    .FAST_TICKS (WIN_FAST_TICKS),
    .SLOW_TICKS (WIN_SLOW_TICKS),
    .TMR_W      (TMR_W)
  ) u_timebase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .speed100_i (speed100_i),
    .tick_o     (tick_w),
    .tmr_o      (tmr_w)
  );

  bsl_classify u_classify (
    .da_i         (da_i),
    .bcast_only_i (bcast_only_i),
    .cls_o        (cls_w),
    .counted_o    (counted_w)
  );

  bsl_gate #(.CNT_W(CNT_W)) u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .tick_i (tick_w),
    .hit_i  (sof_i && counted_w),
    .thr_i  (thr_w),
    .drop_o (drop_o),
    .cnt_o  (cnt_w)
  );
endmodule

// File: rtl/bcast_storm_limiter_chk.sv
module bcast_storm_limiter_chk #(
  parameter int unsigned CNT_W   = 10,
  parameter int unsigned TMR_W   = 23,
  parameter int unsigned WIN_MAX = 5000000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             bcast_only_i,
  input logic             sof_i,
  input logic [47:0]      da_i,
  input logic             drop_o,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] thr_i,
  input logic [TMR_W-1:0] tmr_i,
  input logic             tick_i
);
  p_off_no_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !drop_o);

  p_pulse_after_sof_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i |=> !drop_o);

  p_uncounted_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_i && !(&da_i) && (bcast_only_i || !da_i[40])) |=> !drop_o);

  p_cnt_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i > $past(cnt_i)) |-> (cnt_i == $past(cnt_i) + 1'b1));

  p_drop_at_limit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> ($past(cnt_i) >= $past(thr_i)));

  p_tmr_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_i <= TMR_W'(WIN_MAX - 1));

  p_tick_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (cnt_i <= 1));

  p_off_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_i == '0 && tmr_i == '0));
endmodule

bind bcast_storm_limiter bcast_storm_limiter_chk #(
  .CNT_W   (CNT_W),
  .TMR_W   (TMR_W),
  .WIN_MAX (WIN_MAX)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .bcast_only_i (bcast_only_i),
  .sof_i        (sof_i),
  .da_i         (da_i),
  .drop_o       (drop_o),
  .cnt_i        (cnt_w),
  .thr_i        (thr_w),
  .tmr_i        (tmr_w),
  .tick_i       (tick_w)
);

// File: tb/bcast_storm_limiter_bench.sv
module bcast_storm_limiter_bench;
  localparam int FAST = 200;
  localparam int SLOW = 600;
  localparam int WDOG = 100000;
  localparam logic [47:0] DA_BC  = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] DA_MC  = 48'h0100_5E00_0001;
  localparam logic [47:0] DA_UC  = 48'h0011_2233_4455;

  typedef struct packed {
    logic [1:0]  sel;
    logic        bo;
    logic        spd;
    logic [47:0] da;
    int          n;
    int          pass;
  } vec_t;

  // thr table in bench: 3,5,8,12
  localparam vec_t VEC [7] = '{
    '{2'd0, 1'b1, 1'b1, DA_BC, 6,  3},
    '{2'd1, 1'b1, 1'b1, DA_BC, 8,  5},
    '{2'd2, 1'b1, 1'b0, DA_BC, 10, 8},
    '{2'd3, 1'b0, 1'b1, DA_BC, 15, 12},
    '{2'd0, 1'b1, 1'b1, DA_MC, 6,  6},
    '{2'd0, 1'b0, 1'b1, DA_MC, 6,  3},
    '{2'd0, 1'b0, 1'b1, DA_UC, 6,  6}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic speed100_i = 1'b1;
  logic [1:0] thr_sel_i = 2'd0;
  logic bcast_only_i = 1'b1;
  logic sof_i = 1'b0;
  logic [47:0] da_i = '0;
  logic drop_o;

  int n_checks = 0;
  int n_fail = 0;
  int e = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  bcast_storm_limiter #(
    .WIN_FAST_TICKS (FAST),
    .WIN_SLOW_TICKS (SLOW),
    .THR_SEL0 (3), .THR_SEL1 (5), .THR_SEL2 (8), .THR_SEL3 (12)
  ) u_bcast_storm_limiter (
    .clk_i (clk), .rst_ni (rst_ni), .en_i (en_i), .speed100_i (speed100_i),
    .thr_sel_i (thr_sel_i), .bcast_only_i (bcast_only_i), .sof_i (sof_i),
    .da_i (da_i), .drop_o (drop_o)
  );

  task automatic check(input logic act, input logic exp, input string msg);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b", msg, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] da, input logic exp, input string msg);
    sof_i = 1'b1;
    da_i  = da;
    @(negedge clk);
    sof_i = 1'b0;
    e++;
    check(drop_o, exp, msg);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    e += n;
  endtask

  task automatic restart(input logic spd);
    en_i = 1'b0;
    speed100_i = spd;
    @(negedge clk);
    en_i = 1'b1;
    e = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(drop_o, 1'b0, "R1 drop low in reset");
    rst_ni = 1'b1;
    @(negedge clk);

    // table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < 7; v++) begin
      thr_sel_i    = VEC[v].sel;
      bcast_only_i = VEC[v].bo;
      restart(VEC[v].spd);
      for (int i = 0; i < VEC[v].n; i++)
        send(VEC[v].da, logic'(i >= VEC[v].pass), $sformatf("R5 R6 R2 R3 vec%0d frame%0d", v, i));
    end

    // R4: non-counted frames pass mid-storm
    thr_sel_i = 2'd0; bcast_only_i = 1'b1;
    restart(1'b1);
    for (int i = 0; i < 3; i++) send(DA_BC, 1'b0, "R5 under limit");
    send(DA_BC, 1'b1, "R5 over limit");
    send(DA_UC, 1'b0, "R4 unicast in storm");
    send(DA_MC, 1'b0, "R4 group frame with bcast_only=1");
    send(DA_BC, 1'b1, "R4 count untouched");
    idle(1);
    check(drop_o, 1'b0, "R9 one-cycle pulse");

    // R7 fast window boundary
    restart(1'b1);
    for (int i = 0; i < 3; i++) send(DA_BC, 1'b0, "R7 fast fill");
    send(DA_BC, 1'b1, "R7 fast over");
    idle(FAST - 2 - e);
    send(DA_BC, 1'b1, "R7 edge before boundary");
    send(DA_BC, 1'b0, "R7 boundary frame new window");
    send(DA_BC, 1'b0, "R7 new window 2");
    send(DA_BC, 1'b0, "R7 new window 3");
    send(DA_BC, 1'b1, "R7 new window over");

    // R7 slow window
    restart(1'b0);
    for (int i = 0; i < 3; i++) send(DA_BC, 1'b0, "R7 slow fill");
    idle(FAST - 1 - e);
    send(DA_BC, 1'b1, "R7 slow still dropping at fast length");
    idle(SLOW - 1 - e);
    send(DA_BC, 1'b0, "R7 slow boundary");

    // R8 disabled
    en_i = 1'b0;
    for (int i = 0; i < 6; i++) send(DA_BC, 1'b0, "R8 disabled no drop");

    // R1 reset mid-storm
    restart(1'b1);
    for (int i = 0; i < 4; i++) send(DA_BC, logic'(i >= 3), "R1 pre-reset storm");
    rst_ni = 1'b0;
    @(negedge clk);
    check(drop_o, 1'b0, "R1 reset clears drop");
    rst_ni = 1'b1;
    e = 0;
    for (int i = 0; i < 4; i++) send(DA_BC, logic'(i >= 3), "R1 count cleared by reset");

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule